// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a bank of interrupt sources and turns their activity into delivery requests for the presentation side. A source is either level style, where its line is copied into an asserted flag, or message style, where a rising edge on its line counts as one event. Each source holds a target server, a current priority, a saved priority and four status flags: asserted, sent, rejected and held (an event that arrived while masked). The priority value 0xFF means masked.

The presentation side answers with three notifications: a reject of a source number, an end-of-interrupt for a source number, and a resend request that makes every source reconsider redelivery. A configuration port sets, reads, disables and enables one source at a time and replies one cycle later with an error flag and the read data. A delivery that has become due is queued in the source. The queued sources are issued one at a time on a valid/ready output, lowest source index first, and the output stays stable while it waits for ready.

Source numbers on all ports are global. Local source i is numbered `BASE + i`, and a number outside `[BASE, BASE + NSRC)` names no source.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no delivery is offered and every source reads back server 0 and priority 0xFF.
- R2: A configuration request whose number lies outside [BASE, BASE+NSRC) replies with the error flag set and changes nothing. A reject or end-of-interrupt with such a number is ignored.
- R3: A set request (op 0) whose server is not below NSERV replies with the error flag set and leaves the source unchanged. Every delivered server is below NSERV.
- R4: A rising edge on a message source's line queues one delivery if its priority is not 0xFF. Otherwise the edge sets the held flag. A later configuration write that leaves a non-0xFF priority clears the held flag and queues the delivery. A falling edge does nothing.
- R5: A level source queues a delivery and sets sent when it is unmasked, asserted and not yet sent. This is evaluated on a rising line edge, on a resend and on a configuration write.
- R6: A reject of a source sets its rejected flag and clears its sent flag.
- R7: A resend applies the rule of R5 to every level source. Every message source with rejected set has the flag cleared and queues a delivery if unmasked.
- R8: An end-of-interrupt clears the sent flag of a level source. It has no effect on a message source.
- R9: Set (op 0) writes the given priority to both priority fields. Disable (op 2) writes 0xFF and saves the previous priority. Enable (op 3) copies the saved priority into both. Get (op 1) returns the server and the current priority.
- R10: A delivery carries server, source number BASE+i and current priority. At most one delivery is issued per cycle, the lowest queued unmasked index goes first, and the outputs stay stable while valid is high and ready is low.
- R11: Each configuration request gets an acknowledge exactly one cycle later, and only then. The read fields are zero unless the request was a successful get.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NSRC | Per-source style: 1 level, 0 message |
| src_line | input | NSRC | Per-source interrupt lines |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number for the end-of-interrupt |
| resend | input | 1 | Resend request strobe |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_op | input | 2 | 0 set, 1 get, 2 disable, 3 enable |
| cfg_num | input | NUM_W | Global source number for the request |
| cfg_server | input | SRV_W | Server for a set request |
| cfg_prio | input | PRIO_W | Priority for a set request |
| cfg_ack | output | 1 | Reply strobe, one cycle after the request |
| cfg_err | output | 1 | Request refused |
| cfg_rd_server | output | SRV_W | Server read by a get |
| cfg_rd_prio | output | PRIO_W | Priority read by a get |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery accepted |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_source | output | NUM_W | Global source number of the delivery |
| dlv_prio | output | PRIO_W | Priority of the delivery |

## Verification
The assertions take for granted that the presentation side keeps ready meaningful only while valid is high, that src_level is held constant after reset, and that strobes last a single cycle. The stimulus keeps src_level fixed, drives every strobe for one cycle at the falling edge, and draws source and server numbers from a range slightly wider than the legal window, so both the refused and the accepted cases occur. Ready is dropped at random so that queued deliveries pile up and the hold rule on the output is exercised.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam logic [1:0] OP_SET = 2'd0;
  localparam logic [1:0] OP_GET = 2'd1;
  localparam logic [1:0] OP_OFF = 2'd2;
  localparam logic [1:0] OP_ON  = 2'd3;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic held;
    logic queued;
  } src_flags_t;

  function automatic logic num_in_window(input logic [31:0] num,
                                         input logic [31:0] base,
                                         input logic [31:0] count);
    return (num >= base) && ((num - base) < count);
  endfunction

  function automatic logic names_slot(input logic [31:0] num,
                                      input logic [31:0] base,
                                      input int unsigned idx);
    return num == (base + idx);
  endfunction

  function automatic src_flags_t level_rule(input src_flags_t f, input logic masked);
    src_flags_t r;
    r = f;
    if (!masked && f.asserted && !f.sent) begin
      r.sent   = 1'b1;
      r.queued = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_level,
  input  logic              line,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              resend,
  input  logic              wr_en,
  input  logic [SRV_W-1:0]  wr_server,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [PRIO_W-1:0] wr_saved,
  input  logic              take,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0] saved,
  output logic              eligible
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  src_flags_t        flags, nflags;
  logic              line_q;
  logic              rise;
  logic [SRV_W-1:0]  nserver;
  logic [PRIO_W-1:0] nprio, nsaved;

  assign rise = line & ~line_q;

  always_comb begin
    nflags  = flags;
    nserver = server;
    nprio   = prio;
    nsaved  = saved;
    if (take) nflags.queued = 1'b0;
    if (rej_hit) begin
      nflags.rejected = 1'b1;
      nflags.sent     = 1'b0;
    end
    if (eoi_hit && is_level) nflags.sent = 1'b0;
    if (is_level) begin
      nflags.asserted = line;
      if (rise) nflags = level_rule(nflags, nprio == MASKED);
    end else if (rise) begin
      if (nprio == MASKED) nflags.held = 1'b1;
      else nflags.queued = 1'b1;
    end
    if (resend) begin
      if (is_level) begin
        nflags = level_rule(nflags, nprio == MASKED);
      end else if (nflags.rejected) begin
        nflags.rejected = 1'b0;
        if (nprio != MASKED) nflags.queued = 1'b1;
      end
    end
    if (wr_en) begin
      nserver = wr_server;
      nprio   = wr_prio;
      nsaved  = wr_saved;
      if (is_level) begin
        nflags = level_rule(nflags, nprio == MASKED);
      end else if (nflags.held && (nprio != MASKED)) begin
        nflags.held   = 1'b0;
        nflags.queued = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '0;
      server <= '0;
      prio   <= MASKED;
      saved  <= MASKED;
      line_q <= 1'b0;
    end else begin
      flags  <= nflags;
      server <= nserver;
      prio   <= nprio;
      saved  <= nsaved;
      line_q <= line;
    end
  end

  assign eligible = flags.queued && (prio != MASKED);

endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]  req,
  output logic [NSRC-1:0]  grant,
  output logic [IDX_W-1:0] gidx,
  output logic             any
);

  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        gidx     = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
  import irq_src_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NSERV  = 4,
  parameter int BASE   = 4096,
  parameter int NUM_W  = 16,
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_valid,
  input  logic [1:0]                  cfg_op,
  input  logic [NUM_W-1:0]            cfg_num,
  input  logic [SRV_W-1:0]            cfg_server,
  input  logic [PRIO_W-1:0]           cfg_prio,
  input  logic [NSRC-1:0][SRV_W-1:0]  cur_server,
  input  logic [NSRC-1:0][PRIO_W-1:0] cur_prio,
  input  logic [NSRC-1:0][PRIO_W-1:0] cur_saved,
  output logic [NSRC-1:0]             wr_en,
  output logic [SRV_W-1:0]            wr_server,
  output logic [PRIO_W-1:0]           wr_prio,
  output logic [PRIO_W-1:0]           wr_saved,
  output logic                        cfg_ack,
  output logic                        cfg_err,
  output logic [SRV_W-1:0]            cfg_rd_server,
  output logic [PRIO_W-1:0]           cfg_rd_prio
);

  logic              hit, srv_ok, req_ok;
  logic [NSRC-1:0]   sel;
  logic [SRV_W-1:0]  sel_server;
  logic [PRIO_W-1:0] sel_prio, sel_saved;

  always_comb begin
    hit        = num_in_window(32'(cfg_num), 32'(BASE), 32'(NSRC));
    srv_ok     = 32'(cfg_server) < 32'(NSERV);
    req_ok     = hit && ((cfg_op != OP_SET) || srv_ok);
    sel_server = '0;
    sel_prio   = '0;
    sel_saved  = '0;
    for (int i = 0; i < NSRC; i++) begin
      sel[i] = names_slot(32'(cfg_num), 32'(BASE), i);
      if (sel[i]) begin
        sel_server = cur_server[i];
        sel_prio   = cur_prio[i];
        sel_saved  = cur_saved[i];
      end
    end
    wr_server = sel_server;
    wr_prio   = sel_prio;
    wr_saved  = sel_saved;
    case (cfg_op)
      OP_SET: begin
        wr_server = cfg_server;
        wr_prio   = cfg_prio;
        wr_saved  = cfg_prio;
      end
      OP_OFF: begin
        wr_prio  = '1;
        wr_saved = sel_prio;
      end
      OP_ON: begin
        wr_prio  = sel_saved;
        wr_saved = sel_saved;
      end
      default: ;
    endcase
    wr_en = (cfg_valid && req_ok && (cfg_op != OP_GET)) ? sel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ack       <= 1'b0;
      cfg_err       <= 1'b0;
      cfg_rd_server <= '0;
      cfg_rd_prio   <= '0;
    end else begin
      cfg_ack <= cfg_valid;
      cfg_err <= cfg_valid && !req_ok;
      if (cfg_valid && req_ok && (cfg_op == OP_GET)) begin
        cfg_rd_server <= sel_server;
        cfg_rd_prio   <= sel_prio;
      end else begin
        cfg_rd_server <= '0;
        cfg_rd_prio   <= '0;
      end
    end
  end

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NSERV  = 4,
  parameter int BASE   = 4096,
  parameter int NUM_W  = 16,
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_level,
  input  logic [NSRC-1:0]   src_line,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_op,
  input  logic [NUM_W-1:0]  cfg_num,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  output logic              cfg_ack,
  output logic              cfg_err,
  output logic [SRV_W-1:0]  cfg_rd_server,
  output logic [PRIO_W-1:0] cfg_rd_prio,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [SRV_W-1:0]  dlv_server,
  output logic [NUM_W-1:0]  dlv_source,
  output logic [PRIO_W-1:0] dlv_prio
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]             rej_hit, eoi_hit, wr_en, eligible, grant, take;
  logic [NSRC-1:0][SRV_W-1:0]  srv_arr;
  logic [NSRC-1:0][PRIO_W-1:0] prio_arr, saved_arr;
  logic [SRV_W-1:0]            wr_server;
  logic [PRIO_W-1:0]           wr_prio, wr_saved;
  logic [IDX_W-1:0]            gidx;
  logic                        any_due;
  logic                        load;

  assign load = !dlv_valid || dlv_ready;
  assign take = load ? grant : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    assign rej_hit[i] = rej_valid && names_slot(32'(rej_num), 32'(BASE), i);
    assign eoi_hit[i] = eoi_valid && names_slot(32'(eoi_num), 32'(BASE), i);

    irq_src_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_level (src_level[i]),
      .line     (src_line[i]),
      .rej_hit  (rej_hit[i]),
      .eoi_hit  (eoi_hit[i]),
      .resend   (resend),
      .wr_en    (wr_en[i]),
      .wr_server(wr_server),
      .wr_prio  (wr_prio),
      .wr_saved (wr_saved),
      .take     (take[i]),
      .server   (srv_arr[i]),
      .prio     (prio_arr[i]),
      .saved    (saved_arr[i]),
      .eligible (eligible[i])
    );
  end

  irq_src_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) i_pick (
    .req  (eligible),
    .grant(grant),
    .gidx (gidx),
    .any  (any_due)
  );

  irq_src_cfg #(
    .NSRC(NSRC), .NSERV(NSERV), .BASE(BASE),
    .NUM_W(NUM_W), .SRV_W(SRV_W), .PRIO_W(PRIO_W)
  ) i_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_op       (cfg_op),
    .cfg_num      (cfg_num),
    .cfg_server   (cfg_server),
    .cfg_prio     (cfg_prio),
    .cur_server   (srv_arr),
    .cur_prio     (prio_arr),
    .cur_saved    (saved_arr),
    .wr_en        (wr_en),
    .wr_server    (wr_server),
    .wr_prio      (wr_prio),
    .wr_saved     (wr_saved),
    .cfg_ack      (cfg_ack),
    .cfg_err      (cfg_err),
    .cfg_rd_server(cfg_rd_server),
    .cfg_rd_prio  (cfg_rd_prio)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_server <= '0;
      dlv_source <= '0;
      dlv_prio   <= '0;
    end else if (load) begin
      dlv_valid  <= any_due;
      dlv_server <= srv_arr[gidx];
      dlv_source <= NUM_W'(32'(BASE) + 32'(gidx));
      dlv_prio   <= prio_arr[gidx];
    end
  end

endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk
  import irq_src_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NSERV  = 4,
  parameter int BASE   = 4096,
  parameter int NUM_W  = 16,
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic [1:0]        cfg_op,
  input logic [NUM_W-1:0]  cfg_num,
  input logic [SRV_W-1:0]  cfg_server,
  input logic              cfg_ack,
  input logic              cfg_err,
  input logic              dlv_valid,
  input logic              dlv_ready,
  input logic [SRV_W-1:0]  dlv_server,
  input logic [NUM_W-1:0]  dlv_source,
  input logic [PRIO_W-1:0] dlv_prio,
  input logic [NSRC-1:0]   take
);

  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_server) && $stable(dlv_source) && $stable(dlv_prio)); // R10

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R10

  AST_DLV_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (dlv_prio != '1)); // R4

  AST_DLV_SOURCE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> num_in_window(32'(dlv_source), 32'(BASE), 32'(NSRC))); // R10

  AST_DLV_SERVER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (32'(dlv_server) < 32'(NSERV))); // R3

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_ack); // R11

  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !cfg_ack); // R11

  AST_BAD_NUM_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !num_in_window(32'(cfg_num), 32'(BASE), 32'(NSRC)) |=> cfg_err); // R2

  AST_BAD_SERVER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && (cfg_op == OP_SET) && (32'(cfg_server) >= 32'(NSERV)) |=> cfg_err); // R3

endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(
  .NSRC(NSRC), .NSERV(NSERV), .BASE(BASE),
  .NUM_W(NUM_W), .SRV_W(SRV_W), .PRIO_W(PRIO_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_op    (cfg_op),
  .cfg_num   (cfg_num),
  .cfg_server(cfg_server),
  .cfg_ack   (cfg_ack),
  .cfg_err   (cfg_err),
  .dlv_valid (dlv_valid),
  .dlv_ready (dlv_ready),
  .dlv_server(dlv_server),
  .dlv_source(dlv_source),
  .dlv_prio  (dlv_prio),
  .take      (take)
);

// File: tb/test_irq_source_ctrl.sv
`timescale 1ns/1ps
module test_irq_source_ctrl;

  localparam int NSRC   = 8;
  localparam int NSERV  = 3;
  localparam int BASE   = 100;
  localparam int NUM_W  = 16;
  localparam int SRV_W  = 8;
  localparam int PRIO_W = 8;
  localparam logic [NSRC-1:0] LVL = 8'b1100_0110;
  localparam int OFF = 255;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   src_line = '0;
  logic              rej_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0, cfg_valid = 1'b0;
  logic [NUM_W-1:0]  rej_num = '0, eoi_num = '0, cfg_num = '0;
  logic [1:0]        cfg_op = '0;
  logic [SRV_W-1:0]  cfg_server = '0;
  logic [PRIO_W-1:0] cfg_prio = '0;
  logic              dlv_ready = 1'b1;
  logic              cfg_ack, cfg_err, dlv_valid;
  logic [SRV_W-1:0]  cfg_rd_server, dlv_server;
  logic [PRIO_W-1:0] cfg_rd_prio, dlv_prio;
  logic [NUM_W-1:0]  dlv_source;

  irq_source_ctrl #(
    .NSRC(NSRC), .NSERV(NSERV), .BASE(BASE),
    .NUM_W(NUM_W), .SRV_W(SRV_W), .PRIO_W(PRIO_W)
  ) i_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .src_level(LVL), .src_line(src_line),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend(resend), .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .cfg_rd_server(cfg_rd_server), .cfg_rd_prio(cfg_rd_prio), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_server(dlv_server), .dlv_source(dlv_source), .dlv_prio(dlv_prio)
  );

  always #2 clk = ~clk;

  int    checks = 0, errors = 0, cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Expected state, derived from the requirements
  int m_srv[NSRC], m_pri[NSRC], m_sav[NSRC];
  bit m_ast[NSRC], m_snt[NSRC], m_rej[NSRC], m_hld[NSRC], m_que[NSRC], m_lp[NSRC];
  bit m_v, m_ack, m_err;
  int m_os, m_oc, m_op, m_rs, m_rp;

  task automatic level_due(int i);
    if (m_pri[i] != OFF && m_ast[i] && !m_snt[i]) begin
      m_snt[i] = 1'b1;
      m_que[i] = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        m_srv[i] = 0; m_pri[i] = OFF; m_sav[i] = OFF;
        m_ast[i] = 0; m_snt[i] = 0; m_rej[i] = 0; m_hld[i] = 0; m_que[i] = 0; m_lp[i] = 0;
      end
      m_v = 0; m_ack = 0; m_err = 0; m_os = 0; m_oc = 0; m_op = 0; m_rs = 0; m_rp = 0;
    end else begin
      int g, idx, ws, wp, wv;
      bit load, okc, wr;
      g = -1;
      load = !m_v || dlv_ready;
      if (load) begin
        for (int i = 0; i < NSRC; i++)
          if (g < 0 && m_que[i] && m_pri[i] != OFF) g = i;
        m_v = (g >= 0);
        if (g >= 0) begin m_os = m_srv[g]; m_oc = BASE + g; m_op = m_pri[g]; end
      end
      idx = int'(cfg_num) - BASE;
      okc = (idx >= 0) && (idx < NSRC) && (cfg_op != 2'd0 || int'(cfg_server) < NSERV);
      m_ack = cfg_valid;
      m_err = cfg_valid && !okc;
      m_rs = 0; m_rp = 0;
      wr = cfg_valid && okc && (cfg_op != 2'd1);
      ws = 0; wp = 0; wv = 0;
      if (cfg_valid && okc) begin
        if (cfg_op == 2'd1) begin m_rs = m_srv[idx]; m_rp = m_pri[idx]; end
        case (cfg_op)
          2'd0: begin ws = int'(cfg_server); wp = int'(cfg_prio); wv = int'(cfg_prio); end
          2'd2: begin ws = m_srv[idx]; wp = OFF; wv = m_pri[idx]; end
          default: begin ws = m_srv[idx]; wp = m_sav[idx]; wv = m_sav[idx]; end
        endcase
      end
      for (int i = 0; i < NSRC; i++) begin
        bit rise;
        rise = src_line[i] && !m_lp[i];
        m_lp[i] = src_line[i];
        if (load && g == i) m_que[i] = 0;
        if (rej_valid && int'(rej_num) == BASE + i) begin m_rej[i] = 1; m_snt[i] = 0; end
        if (eoi_valid && int'(eoi_num) == BASE + i && LVL[i]) m_snt[i] = 0;
        if (LVL[i]) begin
          m_ast[i] = src_line[i];
          if (rise) level_due(i);
        end else if (rise) begin
          if (m_pri[i] == OFF) m_hld[i] = 1; else m_que[i] = 1;
        end
        if (resend) begin
          if (LVL[i]) level_due(i);
          else if (m_rej[i]) begin
            m_rej[i] = 0;
            if (m_pri[i] != OFF) m_que[i] = 1;
          end
        end
        if (wr && idx == i) begin
          m_srv[i] = ws; m_pri[i] = wp; m_sav[i] = wv;
          if (LVL[i]) level_due(i);
          else if (m_hld[i] && m_pri[i] != OFF) begin m_hld[i] = 0; m_que[i] = 1; end
        end
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(dlv_valid == m_v, "dlv_valid", int'(dlv_valid), int'(m_v));
      if (dlv_valid && m_v) begin
        chk(int'(dlv_server) == m_os, "dlv_server", int'(dlv_server), m_os);
        chk(int'(dlv_source) == m_oc, "dlv_source", int'(dlv_source), m_oc);
        chk(int'(dlv_prio) == m_op, "dlv_prio", int'(dlv_prio), m_op);
      end
      chk(cfg_ack == m_ack, "cfg_ack (R11)", int'(cfg_ack), int'(m_ack));
      if (cfg_ack && m_ack) begin
        chk(cfg_err == m_err, "cfg_err", int'(cfg_err), int'(m_err));
        chk(int'(cfg_rd_server) == m_rs, "cfg_rd_server", int'(cfg_rd_server), m_rs);
        chk(int'(cfg_rd_prio) == m_rp, "cfg_rd_prio", int'(cfg_rd_prio), m_rp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cfg(int op, int num, int srv, int pri);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = 2'(op); cfg_num = NUM_W'(num);
    cfg_server = SRV_W'(srv); cfg_prio = PRIO_W'(pri);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic pulse_line(int i);
    @(negedge clk); src_line[i] = 1'b1;
    @(negedge clk); src_line[i] = 1'b0;
  endtask

  task automatic set_line(int i, bit v);
    @(negedge clk); src_line[i] = v;
  endtask

  task automatic do_rej(int num);
    @(negedge clk); rej_valid = 1'b1; rej_num = NUM_W'(num);
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic do_eoi(int num);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = NUM_W'(num);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    @(negedge clk); resend = 1'b1;
    @(negedge clk); resend = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    r = int'($urandom(32'd4242));
    idle(5);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1";
    for (int i = 0; i < NSRC; i++) do_cfg(1, BASE + i, 0, 0);

    cur_req = "R2";
    do_cfg(1, BASE - 1, 0, 0);
    do_cfg(0, BASE + NSRC, 1, 4);
    do_rej(BASE - 1);
    do_eoi(BASE + NSRC);

    cur_req = "R3";
    do_cfg(0, BASE, NSERV, 5);
    do_cfg(1, BASE, 0, 0);

    cur_req = "R4";
    pulse_line(0);
    idle(3);
    do_cfg(0, BASE, NSERV - 1, 5);
    idle(3);
    pulse_line(0);
    idle(3);

    cur_req = "R5";
    do_cfg(0, BASE + 1, 1, 3);
    set_line(1, 1'b1);
    idle(3);
    do_resend();
    idle(3);

    cur_req = "R8";
    do_eoi(BASE + 1);
    do_resend();
    idle(3);

    cur_req = "R6";
    do_rej(BASE + 1);
    do_resend();
    idle(3);
    set_line(1, 1'b0);
    do_resend();
    idle(2);

    cur_req = "R7";
    do_rej(BASE);
    do_resend();
    idle(2);
    do_resend();
    idle(2);

    cur_req = "R8";
    do_eoi(BASE);
    do_resend();
    idle(3);

    cur_req = "R9";
    do_cfg(2, BASE, 0, 0);
    do_cfg(1, BASE, 0, 0);
    pulse_line(0);
    idle(2);
    do_cfg(3, BASE, 0, 0);
    idle(2);
    do_cfg(1, BASE, 0, 0);

    cur_req = "R10";
    do_cfg(0, BASE + 3, 0, 2);
    do_cfg(0, BASE + 4, 2, 1);
    @(negedge clk); dlv_ready = 1'b0; src_line[3] = 1'b1; src_line[4] = 1'b1;
    @(negedge clk); src_line[3] = 1'b0; src_line[4] = 1'b0;
    idle(4);
    @(negedge clk); dlv_ready = 1'b1;
    idle(4);

    cur_req = "R11";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      rej_valid = 1'b0; eoi_valid = 1'b0; resend = 1'b0; cfg_valid = 1'b0;
      dlv_ready = ($urandom % 4) != 0;
      r = int'($urandom % 10);
      if (r < 3) begin
        int k;
        k = int'($urandom % NSRC);
        src_line[k] = ~src_line[k];
      end else if (r == 3) begin
        rej_valid = 1'b1; rej_num = NUM_W'(BASE - 1 + int'($urandom % (NSRC + 2)));
      end else if (r == 4) begin
        eoi_valid = 1'b1; eoi_num = NUM_W'(BASE - 1 + int'($urandom % (NSRC + 2)));
      end else if (r == 5) begin
        resend = 1'b1;
      end else if (r < 9) begin
        cfg_valid = 1'b1;
        cfg_op = 2'($urandom % 4);
        cfg_num = NUM_W'(BASE - 1 + int'($urandom % (NSRC + 2)));
        cfg_server = SRV_W'($urandom % (NSERV + 1));
        cfg_prio = (($urandom % 4) == 0) ? PRIO_W'(OFF) : PRIO_W'($urandom % 8);
      end
    end
    @(negedge clk);
    rej_valid = 1'b0; eoi_valid = 1'b0; resend = 1'b0; cfg_valid = 1'b0; dlv_ready = 1'b1;
    idle(20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule